// File: doc/BRIEF.md
# Streaming Kurtosis Band Detector

The block watches a stream of signed 8-bit samples and sorts it into windows of 1024 accepted samples. For each window it decides whether the amplitude distribution looks Gaussian. It does this by asking whether the kurtosis lies in a band around 3. A window that fails the test points to impulsive or structured interference, such as pulses, tones or clipping. A downstream stage can use the verdict to blank or flag the corrupted window.

The ratio of the fourth moment to the squared second moment is never formed. The block works in two passes:

- **First pass.** Each window is written into one half of a two-bank buffer while its sum is accumulated. The mean is that sum shifted right.
- **Second pass.** The window is read back from the buffer while the next window fills the other bank. The second and fourth central moment sums are accumulated.
- **Band check.** The squared second-moment sum is scaled by a lower and an upper fixed-point bound, each through a pipelined constant multiplier. The scaled fourth-moment sum is compared against both products, and the two comparisons are combined by AND.

The design accepts one sample per clock without stalling.

Top module: `kurt_detector`

## Requirements
- R1: A synchronous active-high reset clears `out_valid` and `out_gaussian` and discards any partly collected window, so the next accepted sample becomes sample 0 of a fresh window.
- R2: Only cycles with `in_valid` high are accepted. Data on cycles with `in_valid` low has no effect. Exactly one verdict is produced for every 1024 accepted samples.
- R3: `out_valid` is a one-cycle pulse, and `out_gaussian` is 0 in every cycle in which `out_valid` is 0.
- R4: The window mean µ is the two's-complement sum of the 1024 samples shifted arithmetically right by 10 (a floor division). The moment sums are S2 = Σ(x−µ)² and S4 = Σ(x−µ)⁴, taken over the window's own samples.
- R5: `out_gaussian` is 1 exactly when 2^18·S4 ≥ 640·S2² and 2^18·S4 ≤ 896·S2². This is the kurtosis band [2.5, 3.5], with the bounds held as values with 8 fractional bits and the factor 2^18 = 1024·256.
- R6: A window whose samples are all equal (S2 = 0) gives `out_gaussian` = 0.
- R7: Full-scale windows, including those that alternate between −128 and +127, are evaluated without overflow. S2 never exceeds 1024·255².
- R8: With `in_valid` held high continuously, windows follow each other back to back. Each verdict belongs to its own window, and successive verdicts are exactly 1024 cycles apart.
- R9: `out_valid` rises on the 1034th rising edge after the edge that accepts a window's last sample. That edge is the N + 7 + multiplier-latency edge, where the multiplier latency is 3 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; the sample is accepted when this is high |
| in_sample | input | 8 | Signed two's-complement input sample |
| out_valid | output | 1 | One-cycle pulse marking a window verdict |
| out_gaussian | output | 1 | Verdict: 1 = Gaussian-like, 0 = non-Gaussian or zero variance |

## Verification
With samples arriving every cycle, the first pass collects window k+1 into one bank in the same cycles in which the second pass reads window k out of the other bank. The last read of a window also shares a cycle with the window-boundary restart of the read pipeline. The bench provokes both by streaming a Gaussian-like window and a square-wave window with no gap between them. It then requires two verdicts exactly 1024 cycles apart, each matching the value the bench computes for that window's own mean and moments. A mean that leaks from one window into the tail of the previous one, or a bank that is mixed up, shows up as a wrong verdict or a wrong spacing.

// File: rtl/kurt_pkg.sv
package kurt_pkg;

  // Tag carried alongside each element of the readout pipeline.
  typedef struct packed {
    logic v;      // element valid
    logic first;  // first element of a window: restart accumulators
    logic last;   // last element of a window: publish sums
  } kurt_tag_t;

  localparam kurt_tag_t KURT_TAG_IDLE = '{v: 1'b0, first: 1'b0, last: 1'b0};

endpackage

// File: rtl/kurt_bank_ram.sv
module kurt_bank_ram #(
  parameter int W   = 8,
  parameter int A_W = 11
) (
  input  logic                clk,
  input  logic                we,
  input  logic [A_W-1:0]      waddr,
  input  logic signed [W-1:0] wdata,
  input  logic [A_W-1:0]      raddr,
  output logic signed [W-1:0] rdata
);

  localparam int DEPTH = 1 << A_W;

  logic signed [W-1:0] mem [DEPTH];

  // Simple dual-port memory with a registered read, suitable for block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/kurt_collect.sv
module kurt_collect #(
  parameter int W      = 8,
  parameter int N_LOG2 = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_sample,
  output logic                we,
  output logic [N_LOG2:0]     waddr,
  output logic signed [W-1:0] wdata,
  output logic                done,
  output logic                done_bank,
  output logic signed [W-1:0] done_mean
);

  localparam int SUM_W = W + N_LOG2;

  logic [N_LOG2-1:0]       idx;
  logic                    bank;
  logic signed [SUM_W-1:0] sum_r;
  logic signed [SUM_W-1:0] sum_next;
  logic                    at_last;

  assign at_last  = &idx;
  assign sum_next = ((idx == '0) ? SUM_W'(0) : sum_r) + SUM_W'(in_sample);

  assign we    = in_valid;
  assign waddr = {bank, idx};
  assign wdata = in_sample;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      bank      <= 1'b0;
      sum_r     <= '0;
      done      <= 1'b0;
      done_bank <= 1'b0;
      done_mean <= '0;
    end else begin
      done <= 1'b0;
      if (in_valid) begin
        idx   <= idx + 1'b1;
        sum_r <= sum_next;
        if (at_last) begin
          done      <= 1'b1;
          done_bank <= bank;
          done_mean <= W'(sum_next >>> N_LOG2);
          bank      <= ~bank;
        end
      end
    end
  end

endmodule

// File: rtl/kurt_moments.sv
module kurt_moments
  import kurt_pkg::*;
#(
  parameter int W      = 8,
  parameter int N_LOG2 = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      start_bank,
  input  logic signed [W-1:0]       start_mean,
  output logic [N_LOG2:0]           raddr,
  input  logic signed [W-1:0]       rdata,
  output logic                      done,
  output logic [2*(W+1)+N_LOG2-1:0] s2_sum,
  output logic [4*(W+1)+N_LOG2-1:0] s4_sum
);

  localparam int D_W  = W + 1;
  localparam int D2_W = 2 * D_W;
  localparam int D4_W = 2 * D2_W;
  localparam int S2_W = D2_W + N_LOG2;
  localparam int S4_W = D4_W + N_LOG2;

  logic                running;
  logic [N_LOG2-1:0]   ridx;
  logic                bank_r;
  logic signed [W-1:0] mean_r;

  kurt_tag_t tag0, tag1, tag2, tag3, tag4;

  logic signed [W-1:0]    mean1;
  logic signed [D_W-1:0]  d_r;
  logic signed [D2_W-1:0] dsq;
  logic [D2_W-1:0]        d2_r, d2_d;
  logic [D4_W-1:0]        d4_r;
  logic [S2_W-1:0]        s2_acc;
  logic [S4_W-1:0]        s4_acc;
  logic [S2_W-1:0]        s2_next;
  logic [S4_W-1:0]        s4_next;

  assign raddr = {bank_r, ridx};
  assign tag0  = '{v: running, first: running && (ridx == '0), last: running && (&ridx)};
  assign dsq   = d_r * d_r;

  // Read sequencer: a new start takes priority, so windows may follow back to back.
  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      ridx    <= '0;
      bank_r  <= 1'b0;
      mean_r  <= '0;
    end else if (start) begin
      running <= 1'b1;
      ridx    <= '0;
      bank_r  <= start_bank;
      mean_r  <= start_mean;
    end else if (running) begin
      ridx <= ridx + 1'b1;
      if (&ridx) running <= 1'b0;
    end
  end

  // Element pipeline: RAM read, centering, square, fourth power. The mean travels
  // with its element so that a new window's start cannot disturb the old tail.
  always_ff @(posedge clk) begin
    if (rst) begin
      tag1 <= KURT_TAG_IDLE;
      tag2 <= KURT_TAG_IDLE;
      tag3 <= KURT_TAG_IDLE;
      tag4 <= KURT_TAG_IDLE;
    end else begin
      tag1 <= tag0;
      tag2 <= tag1;
      tag3 <= tag2;
      tag4 <= tag3;
    end
  end

  always_ff @(posedge clk) begin
    mean1 <= mean_r;
    d_r   <= {rdata[W-1], rdata} - {mean1[W-1], mean1};
    d2_r  <= $unsigned(dsq);
    d4_r  <= D4_W'(d2_r) * D4_W'(d2_r);
    d2_d  <= d2_r;
  end

  assign s2_next = (tag4.first ? S2_W'(0) : s2_acc) + S2_W'(d2_d);
  assign s4_next = (tag4.first ? S4_W'(0) : s4_acc) + S4_W'(d4_r);

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_acc <= '0;
      s4_acc <= '0;
      done   <= 1'b0;
      s2_sum <= '0;
      s4_sum <= '0;
    end else begin
      done <= 1'b0;
      if (tag4.v) begin
        s2_acc <= s2_next;
        s4_acc <= s4_next;
        if (tag4.last) begin
          done   <= 1'b1;
          s2_sum <= s2_next;
          s4_sum <= s4_next;
        end
      end
    end
  end

endmodule

// File: rtl/kurt_band_check.sv
module kurt_band_check #(
  parameter int S2_W    = 28,
  parameter int S4_W    = 46,
  parameter int N_LOG2  = 10,
  parameter int FRAC    = 8,
  parameter int K_W     = 12,
  parameter int K_LO    = 640,
  parameter int K_HI    = 896,
  parameter int MUL_LAT = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_v,
  input  logic [S2_W-1:0] s2_in,
  input  logic [S4_W-1:0] s4_in,
  output logic            out_v,
  output logic            out_g
);

  localparam int SQ_W  = 2 * S2_W;
  localparam int CMP_W = SQ_W + K_W;
  localparam int SHIFT = N_LOG2 + FRAC;
  localparam logic [K_W-1:0] LO_C = K_W'(K_LO);
  localparam logic [K_W-1:0] HI_C = K_W'(K_HI);

  logic            v1, nz1;
  logic [SQ_W-1:0] sq1;
  logic [CMP_W-1:0] n4_1;

  logic [CMP_W-1:0] lo_p [MUL_LAT];
  logic [CMP_W-1:0] hi_p [MUL_LAT];
  logic [CMP_W-1:0] n4_p [MUL_LAT];
  logic             nz_p [MUL_LAT];
  logic             v_p  [MUL_LAT];

  // Square of the second-moment sum and the scaled fourth-moment term.
  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_v;
    nz1  <= (s2_in != '0);
    sq1  <= SQ_W'(s2_in) * SQ_W'(s2_in);
    n4_1 <= CMP_W'(s4_in) << SHIFT;
  end

  // Constant multipliers with MUL_LAT registers; the other paths are matched.
  for (genvar k = 0; k < MUL_LAT; k++) begin : g_mul
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) v_p[k] <= 1'b0;
        else     v_p[k] <= v1;
        lo_p[k] <= CMP_W'(sq1) * CMP_W'(LO_C);
        hi_p[k] <= CMP_W'(sq1) * CMP_W'(HI_C);
        n4_p[k] <= n4_1;
        nz_p[k] <= nz1;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) v_p[k] <= 1'b0;
        else     v_p[k] <= v_p[k-1];
        lo_p[k] <= lo_p[k-1];
        hi_p[k] <= hi_p[k-1];
        n4_p[k] <= n4_p[k-1];
        nz_p[k] <= nz_p[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v <= 1'b0;
      out_g <= 1'b0;
    end else begin
      out_v <= v_p[MUL_LAT-1];
      out_g <= v_p[MUL_LAT-1] && nz_p[MUL_LAT-1]
            && (n4_p[MUL_LAT-1] >= lo_p[MUL_LAT-1])
            && (n4_p[MUL_LAT-1] <= hi_p[MUL_LAT-1]);
    end
  end

endmodule

// File: rtl/kurt_detector.sv
module kurt_detector #(
  parameter int W       = 8,
  parameter int N_LOG2  = 10,
  parameter int FRAC    = 8,
  parameter int K_W     = 12,
  parameter int K_LO    = 640,
  parameter int K_HI    = 896,
  parameter int MUL_LAT = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_sample,
  output logic                out_valid,
  output logic                out_gaussian
);

  localparam int A_W  = N_LOG2 + 1;
  localparam int S2_W = 2 * (W + 1) + N_LOG2;
  localparam int S4_W = 4 * (W + 1) + N_LOG2;

  logic                we;
  logic [A_W-1:0]      waddr, raddr;
  logic signed [W-1:0] wdata, rdata;
  logic                win_done, win_bank;
  logic signed [W-1:0] win_mean;
  logic                mom_done;
  logic [S2_W-1:0]     s2_sum;
  logic [S4_W-1:0]     s4_sum;

  kurt_collect #(.W(W), .N_LOG2(N_LOG2)) u_collect (
    .clk, .rst, .in_valid, .in_sample,
    .we, .waddr, .wdata,
    .done(win_done), .done_bank(win_bank), .done_mean(win_mean)
  );

  kurt_bank_ram #(.W(W), .A_W(A_W)) u_ram (
    .clk, .we, .waddr, .wdata, .raddr, .rdata
  );

  kurt_moments #(.W(W), .N_LOG2(N_LOG2)) u_moments (
    .clk, .rst,
    .start(win_done), .start_bank(win_bank), .start_mean(win_mean),
    .raddr, .rdata,
    .done(mom_done), .s2_sum, .s4_sum
  );

  kurt_band_check #(
    .S2_W(S2_W), .S4_W(S4_W), .N_LOG2(N_LOG2), .FRAC(FRAC),
    .K_W(K_W), .K_LO(K_LO), .K_HI(K_HI), .MUL_LAT(MUL_LAT)
  ) u_band (
    .clk, .rst,
    .in_v(mom_done), .s2_in(s2_sum), .s4_in(s4_sum),
    .out_v(out_valid), .out_g(out_gaussian)
  );

endmodule

// File: rtl/kurt_detector_chk.sv
module kurt_detector_chk #(
  parameter int W      = 8,
  parameter int N_LOG2 = 10,
  parameter int S2_W   = 28
) (
  input logic            clk,
  input logic            rst,
  input logic            out_valid,
  input logic            out_gaussian,
  input logic            win_done,
  input logic            mom_done,
  input logic [S2_W-1:0] s2_sum
);

  localparam longint N_L    = longint'(1) << N_LOG2;
  localparam longint FS     = (longint'(1) << W) - 1;
  localparam longint S2_MAX = N_L * FS * FS;

  logic [15:0] wins, verds;
  logic [31:0] gap;
  logic        seen;
  logic        zero_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      wins         <= '0;
      verds        <= '0;
      gap          <= '0;
      seen         <= 1'b0;
      zero_pending <= 1'b0;
    end else begin
      if (win_done)  wins  <= wins + 1'b1;
      if (out_valid) verds <= verds + 1'b1;
      if (out_valid) begin
        gap  <= 32'd1;
        seen <= 1'b1;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
      if (mom_done) zero_pending <= (s2_sum == '0);
    end
  end

  // R3: verdict strobe lasts one cycle, and the verdict bit is quiet without it
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  p_quiet_verdict_r3: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_gaussian);

  // R2: every verdict follows a completed window, and verdicts are a window apart
  p_verdict_follows_window_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (wins > verds));
  p_window_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && seen) |-> (gap >= 32'(N_L)));

  // R7: the second-moment sum stays inside its full-scale bound
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    mom_done |-> (64'(s2_sum) <= 64'(S2_MAX)));

  // R6: zero variance can never be judged Gaussian
  p_zero_var_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && zero_pending) |-> !out_gaussian);

endmodule

bind kurt_detector kurt_detector_chk #(
  .W(W), .N_LOG2(N_LOG2), .S2_W(S2_W)
) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_gaussian(out_gaussian),
  .win_done(win_done), .mom_done(mom_done), .s2_sum(s2_sum)
);

// File: tb/kurt_detector_tb.sv
`timescale 1ns/1ps
module kurt_detector_tb;

  localparam int N   = 1024;
  localparam int LAT = N + 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic signed [7:0] in_sample = '0;
  logic              out_valid, out_gaussian;

  always #2 clk = ~clk;  // 250 MHz

  kurt_detector u_dut (
    .clk, .rst, .in_valid, .in_sample, .out_valid, .out_gaussian
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int nv    = 0;
  bit vq [64];
  int vcyc [64];
  bit [31:0] rs = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && out_valid && nv < 64) begin
      vq[nv]   = out_gaussian;
      vcyc[nv] = cyc;
      nv++;
    end
    if (!rst && !out_valid && out_gaussian) begin
      n_chk++; n_bad++;
      $display("FAIL R3 out_gaussian high without out_valid: act=1 exp=0");
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit [31:0] rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  function automatic int uni(input int half);
    return int'(rnd() % 32'(2 * half)) - half;
  endfunction

  // kinds: 0 narrow Gaussian-like, 1 square wave, 2 wide uniform, 3 impulsive,
  //        4 constant, 5 full-scale alternation, 6 wide Gaussian-like
  task automatic gen(input int kind, output logic signed [7:0] a [N]);
    for (int i = 0; i < N; i++) begin
      int s = 0;
      case (kind)
        0: for (int j = 0; j < 8; j++) s += uni(8);
        1: s = ((i / 16) % 2 == 0) ? 40 : -40;
        2: s = uni(128);
        3: begin
             for (int j = 0; j < 4; j++) s += uni(4);
             if (i % 128 == 5) s = (i % 256 == 5) ? 120 : -120;
           end
        4: s = 5;
        5: s = (i % 2 == 0) ? -128 : 127;
        default: for (int j = 0; j < 8; j++) s += uni(16);
      endcase
      a[i] = 8'(s);
    end
  endtask

  // R4/R5/R6: floor mean, central moment sums, band [640,896]/256 with 2^18 scale
  function automatic bit model(input logic signed [7:0] a [N]);
    int sum = 0;
    int mu;
    longint s2 = 0, s4 = 0;
    logic [127:0] lhs, lo, hi;
    for (int i = 0; i < N; i++) sum += int'(a[i]);
    mu = sum >>> 10;
    for (int i = 0; i < N; i++) begin
      longint d = longint'(int'(a[i]) - mu);
      s2 += d * d;
      s4 += d * d * d * d;
    end
    lhs = 128'(s4) << 18;
    lo  = 128'(s2) * 128'(s2) * 128'(640);
    hi  = 128'(s2) * 128'(s2) * 128'(896);
    return (s2 != 0) && (lhs >= lo) && (lhs <= hi);
  endfunction

  task automatic drive(input logic signed [7:0] a [N], input int gap_every);
    for (int i = 0; i < N; i++) begin
      if (gap_every > 0 && i % gap_every == 0) begin
        @(negedge clk); in_valid = 1'b0; in_sample = 8'sd127;
      end
      @(negedge clk); in_valid = 1'b1; in_sample = a[i];
    end
  endtask

  task automatic wait_verdicts(input int target);
    int t = 0;
    while (nv < target && t < 4000) begin
      @(negedge clk); t++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(out_gaussian == 1'b0, "R1", "out_gaussian after reset", out_gaussian, 0);
  endtask

  task automatic t_window(input int kind, input string req, input int gap_every);
    logic signed [7:0] a [N];
    int base, t_last;
    bit exp;
    gen(kind, a);
    exp  = model(a);
    base = nv;
    drive(a, gap_every);
    @(negedge clk); in_valid = 1'b0; t_last = cyc;
    wait_verdicts(base + 1);
    check(nv == base + 1, req, "verdict count", nv - base, 1);
    if (nv == base + 1) begin
      check(vq[base] == exp, req, $sformatf("verdict kind %0d", kind), vq[base], exp);
      check(vcyc[base] - t_last == LAT, "R9", "verdict latency", vcyc[base] - t_last, LAT);
    end
  endtask

  task automatic t_back_to_back();
    logic signed [7:0] a [N];
    logic signed [7:0] b [N];
    int base;
    bit ea, eb;
    gen(0, a); gen(1, b);
    ea = model(a); eb = model(b);
    base = nv;
    drive(a, 0);
    drive(b, 0);
    @(negedge clk); in_valid = 1'b0;
    wait_verdicts(base + 2);
    check(nv == base + 2, "R8", "back-to-back verdict count", nv - base, 2);
    if (nv == base + 2) begin
      check(vq[base] == ea, "R8", "first window verdict", vq[base], ea);
      check(vq[base+1] == eb, "R8", "second window verdict", vq[base+1], eb);
      check(vcyc[base+1] - vcyc[base] == N, "R8", "verdict spacing",
            vcyc[base+1] - vcyc[base], N);
    end
  endtask

  task automatic t_mid_reset();
    logic signed [7:0] junk [N];
    int base;
    gen(5, junk);
    base = nv;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); in_valid = 1'b1; in_sample = junk[i];
    end
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(out_valid == 1'b0, "R1", "out_valid during restart", out_valid, 0);
    check(nv == base, "R1", "no verdict from partial window", nv - base, 0);
    t_window(0, "R1", 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: act=%0d exp=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_window(0, "R5", 0);   // Gaussian-like, narrow
    t_window(6, "R5", 0);   // Gaussian-like, wide
    t_window(1, "R5", 0);   // square wave: kurtosis 1
    t_window(2, "R4", 0);   // uniform: kurtosis 1.8
    t_window(3, "R5", 0);   // impulsive: heavy tails
    t_window(4, "R6", 0);   // constant window
    t_window(5, "R7", 0);   // full-scale alternation
    t_window(0, "R2", 3);   // idle cycles carrying junk data
    t_back_to_back();
    t_mid_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule